// File: doc/BRIEF.md
# Serial Link Word Aligner

This block rebuilds 7-bit parallel words from a group of source-synchronous serial data lanes. All lanes in the group share one frame clock. Capture logic upstream samples every lane once per bit time. It also samples the frame clock itself, and that sampled clock is treated as one more lane. The block receives these samples as a stream of bit slices. It shifts each lane through a shift register, finds the word boundary by looking at the sampled clock lane, and delivers four lanes of seven bits, 28 bits in all, once per frame clock period.

The frame clock is nominally high for four bit times and low for three. The delay between the sampled clock and the data lanes is not known in advance, so the block applies a selectable bit offset of 0 to 6 between the two. A small search controller advances the offset until the downstream logic reports valid words. It then holds that offset while valid words keep arriving.

Some transmitters do not produce a clean 4:3 clock. For these, a second mode matches only the clock lane's low-to-high transition. A guard in this mode stops a second word from being read within one word period of the previous one.

The input is a stream in which `in_valid` marks a bit slice. Cycles with `in_valid` low are skipped entirely, so the upstream capture may deliver samples at any average rate up to one per cycle. A serial source cannot be stalled, so the block has no ready output and takes every slice offered. The output is a strobe with no back-pressure: a consumer must take `out_word` in the cycle where `out_valid` is high. `out_word` then holds its value until the next strobe.

Top module: `word_aligner`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` and `locked` are 0, `offset` is 0 and `out_word` is all zeros.
- R2: In pattern mode (`edge_mode`=0), `out_valid` pulses for one cycle, in the cycle after a slice is accepted, exactly when the last seven accepted clock-lane samples read 1,1,1,1,0,0,0 from oldest to newest. A clock with any other shape produces no strobe.
- R3: Lane i of the word sits in `out_word[7i+6:7i]`, and the first bit received on that lane is at position 7i+6. At offset 0 the data bits are the seven data samples accepted together with the matched clock-lane window.
- R4: At offset k, the data bits are the seven data samples accepted k slices before the matched clock-lane window.
- R5: In edge mode (`edge_mode`=1), a strobe follows the slice that completes a seven-sample window. The window's oldest clock-lane sample must be 1, and the clock-lane sample accepted just before that window must be 0.
- R6: In edge mode, no strobe is produced fewer than seven accepted slices after the previous strobe. The count runs across both modes.
- R7: A cycle with `in_valid` low shifts nothing, produces no strobe in the following cycle, and is not counted by the guard.
- R8: On a strobe with `data_ok` low, a miss is counted. After 8 (`MISS_LIMIT`) consecutive misses, `offset` advances by one in the next cycle, wrapping from 6 to 0, and the miss count clears. `offset` changes in no other way.
- R9: `locked` goes to 1 in the cycle after a strobe with `data_ok` high, and to 0 in the cycle after a strobe with `data_ok` low. A strobe with `data_ok` high also clears the miss count.
- R10: `out_word` changes only in a cycle where `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, one slice at most per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The slice on `in_lanes`/`in_fclk` is valid this cycle |
| in_lanes | input | LANES (4) | One sample per data lane |
| in_fclk | input | 1 | Sample of the frame clock lane |
| edge_mode | input | 1 | 0: full 4:3 pattern match, 1: rising-edge match with guard |
| data_ok | input | 1 | Downstream verdict on the word strobed this cycle |
| out_valid | output | 1 | One-cycle strobe for an aligned word |
| out_word | output | 7*LANES (28) | Recovered word, lane i at [7i+6:7i] |
| offset | output | 3 | Current clock-to-data bit offset, 0..6 |
| locked | output | 1 | The last strobed word was judged valid |

## Verification
The bench runs a conforming 4:3 clock and a 5:2 clock, which pattern mode must reject. It also sends a clock with a spurious high bit inside its low phase, which edge mode must not turn into a second word. A guard that was missing or counted idle cycles would emit an extra word that the scoreboard has no entry for.

The offset is swept past a target of 3 and then around the wrap from 6 back to 0. A search that stepped early, failed to wrap or failed to clear its miss count would leave `offset` out of step with the model and garble every following word. Idle gaps are spread randomly through the stream. A design that shifted on idle cycles would slide the data bits, and one that extracted bits in the wrong order or from the wrong slice would fail the word comparison.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
  // How the word boundary is found on the sampled clock lane
  typedef enum logic {
    ALIGN_PATTERN = 1'b0,  // full high/low shape of the frame clock
    ALIGN_RISE    = 1'b1   // low-to-high transition only, with a guard
  } align_mode_e;
endpackage

// File: rtl/lane_shifter.sv
module lane_shifter
  import aligner_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int WORD    = 7,
  parameter int MAX_OFF = 6,
  localparam int OFF_W  = $clog2(MAX_OFF + 1),
  localparam int DEPTH  = WORD + MAX_OFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_en,
  input  logic [LANES-1:0]      lanes_in,
  input  logic [OFF_W-1:0]      offset,
  output logic [LANES*WORD-1:0] word_o
);
  localparam int NCAND = 2 ** OFF_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DEPTH-1:0] sr_q;
    logic [DEPTH-1:0] sr_nxt;
    logic [WORD-1:0]  cand [NCAND];

    // newest sample enters at bit 0, older samples move up
    assign sr_nxt = {sr_q[DEPTH-2:0], lanes_in[g]};

    always_ff @(posedge clk) begin
      if (!rst_n)        sr_q <= '0;
      else if (shift_en) sr_q <= sr_nxt;
    end

    // one candidate window per offset value; unused codes alias offset 0
    for (genvar k = 0; k < NCAND; k++) begin : g_cand
      if (k <= MAX_OFF) begin : g_real
        assign cand[k] = sr_nxt[k+WORD-1:k];
      end else begin : g_alias
        assign cand[k] = sr_nxt[WORD-1:0];
      end
    end

    assign word_o[g*WORD +: WORD] = cand[offset];
  end
endmodule

// File: rtl/boundary_detect.sv
module boundary_detect
  import aligner_pkg::*;
#(
  parameter int WORD    = 7,
  localparam int GRD_W  = $clog2(WORD),
  localparam int HI     = (WORD + 1) / 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        shift_en,
  input  logic        fclk_in,
  input  align_mode_e mode,
  output logic        hit
);
  localparam logic [WORD-1:0] PATTERN = WORD'(((1 << HI) - 1) << (WORD - HI));
  localparam logic [GRD_W-1:0] GRD_OPEN = GRD_W'(WORD - 1);

  logic [WORD-1:0]  ck_q;
  logic [WORD:0]    ck_nxt;
  logic [GRD_W-1:0] guard_q;
  logic             pat_hit, rise_hit;

  assign ck_nxt   = {ck_q, fclk_in};
  assign pat_hit  = (ck_nxt[WORD-1:0] == PATTERN);
  // window starts with a 1 that directly follows a 0, and the guard is open
  assign rise_hit = (ck_nxt[WORD:WORD-1] == 2'b01) && (guard_q == GRD_OPEN);
  assign hit      = shift_en && ((mode == ALIGN_RISE) ? rise_hit : pat_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_q    <= '0;
      guard_q <= GRD_OPEN;
    end else if (shift_en) begin
      ck_q <= ck_nxt[WORD-1:0];
      if (hit)                      guard_q <= '0;
      else if (guard_q != GRD_OPEN) guard_q <= guard_q + 1'b1;
    end
  end
endmodule

// File: rtl/offset_search.sv
module offset_search #(
  parameter int MAX_OFF    = 6,
  parameter int MISS_LIMIT = 8,
  localparam int OFF_W     = $clog2(MAX_OFF + 1),
  localparam int MISS_W    = $clog2(MISS_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_valid,
  input  logic             data_ok,
  output logic [OFF_W-1:0] offset,
  output logic             locked
);
  localparam logic [OFF_W-1:0]  OFF_TOP  = OFF_W'(MAX_OFF);
  localparam logic [MISS_W-1:0] MISS_TOP = MISS_W'(MISS_LIMIT - 1);

  logic [MISS_W-1:0] miss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offset <= '0;
      locked <= 1'b0;
      miss_q <= '0;
    end else if (word_valid) begin
      if (data_ok) begin
        locked <= 1'b1;
        miss_q <= '0;
      end else begin
        locked <= 1'b0;
        if (miss_q == MISS_TOP) begin
          miss_q <= '0;
          offset <= (offset == OFF_TOP) ? '0 : offset + 1'b1;
        end else begin
          miss_q <= miss_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/word_aligner.sv
module word_aligner
  import aligner_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int WORD       = 7,
  parameter int MAX_OFF    = 6,
  parameter int MISS_LIMIT = 8,
  localparam int OFF_W     = $clog2(MAX_OFF + 1),
  localparam int OUT_W     = LANES * WORD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [LANES-1:0] in_lanes,
  input  logic             in_fclk,
  input  logic             edge_mode,
  input  logic             data_ok,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word,
  output logic [OFF_W-1:0] offset,
  output logic             locked
);
  logic             boundary;
  logic [OUT_W-1:0] word_now;

  lane_shifter #(
    .LANES(LANES), .WORD(WORD), .MAX_OFF(MAX_OFF)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
    .lanes_in(in_lanes), .offset(offset), .word_o(word_now)
  );

  boundary_detect #(
    .WORD(WORD)
  ) u_bound (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
    .fclk_in(in_fclk), .mode(align_mode_e'(edge_mode)), .hit(boundary)
  );

  offset_search #(
    .MAX_OFF(MAX_OFF), .MISS_LIMIT(MISS_LIMIT)
  ) u_search (
    .clk(clk), .rst_n(rst_n), .word_valid(out_valid),
    .data_ok(data_ok), .offset(offset), .locked(locked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= boundary;
      if (boundary) out_word <= word_now;
    end
  end
endmodule

// File: rtl/aligner_checker.sv
module aligner_checker #(
  parameter int LANES   = 4,
  parameter int WORD    = 7,
  parameter int MAX_OFF = 6,
  localparam int OFF_W  = $clog2(MAX_OFF + 1),
  localparam int OUT_W  = LANES * WORD
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             data_ok,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_word,
  input logic [OFF_W-1:0] offset,
  input logic             locked
);
  localparam logic [OFF_W-1:0] OFF_TOP = OFF_W'(MAX_OFF);

  // R2: a conforming window cannot recur one slice later
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7: idle slice yields no strobe
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8: offset stays in range
  p_offset_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    offset <= OFF_TOP);

  // R8: offset only ever steps by one with wrap
  p_offset_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset) |->
      (offset == (($past(offset) == OFF_TOP) ? '0 : $past(offset) + 1'b1)));

  // R8: offset moves only after a strobe
  p_offset_after_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset) |-> $past(out_valid && !data_ok));

  // R9: lock gained only after a good word
  p_lock_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(out_valid && data_ok));

  // R9: lock lost only after a bad word
  p_lock_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(out_valid && !data_ok));

  // R10: word holds between strobes
  p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_word) |-> out_valid);
endmodule

bind word_aligner aligner_checker #(
  .LANES(LANES), .WORD(WORD), .MAX_OFF(MAX_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data_ok(data_ok),
  .out_valid(out_valid), .out_word(out_word), .offset(offset), .locked(locked)
);

// File: tb/word_aligner_bench.sv
`timescale 1ns/1ps
module word_aligner_bench;
  localparam int LANES = 4;
  localparam int W     = 7;
  localparam int MISS  = 8;
  localparam int OW    = LANES * W;
  localparam int HB    = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [LANES-1:0] in_lanes = '0;
  logic             in_fclk = 1'b0;
  logic             edge_mode = 1'b0;
  logic             data_ok;
  logic             out_valid;
  logic [OW-1:0]    out_word;
  logic [2:0]       offset;
  logic             locked;

  logic dok_en = 1'b0;
  int   target_off = 0;
  assign data_ok = dok_en && (offset == 3'(target_off));

  word_aligner u_word_aligner (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lanes(in_lanes),
    .in_fclk(in_fclk), .edge_mode(edge_mode), .data_ok(data_ok),
    .out_valid(out_valid), .out_word(out_word), .offset(offset), .locked(locked)
  );

  // bench state
  logic [LANES:0] hist [0:8191];
  int             n = HB - 1;
  int             last_strobe = -100;
  logic [OW-1:0]  exp_q [$];
  int             m_off = 0, m_miss = 0;
  logic           m_locked = 1'b0;
  logic [OW-1:0]  last_word = '0;
  bit             pend = 0;
  bit             mon_on = 0;
  bit             done = 0;
  int             checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // driver: one accepted slice; predicts strobes from R2/R3/R4/R5/R6
  task automatic push_sample(input logic ck, input logic [LANES-1:0] d);
    logic [W-1:0]  win;
    logic [OW-1:0] w;
    bit            hit;
    @(posedge clk); #1;
    in_valid = 1'b1; in_fclk = ck; in_lanes = d;
    n++;
    hist[n] = {ck, d};
    for (int b = 0; b < W; b++) win[W-1-b] = hist[n-W+1+b][LANES];
    if (!edge_mode) hit = (win == 7'b1111000);
    else hit = !hist[n-W][LANES] && hist[n-W+1][LANES] && (n - last_strobe >= W);
    if (hit) begin
      last_strobe = n;
      for (int i = 0; i < LANES; i++)
        for (int b = 0; b < W; b++)
          w[i*W + W-1-b] = hist[n - m_off - (W-1) + b][i];
      exp_q.push_back(w);
    end
  endtask

  // R7: idle slice with noise on the lanes
  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0; in_fclk = 1'($urandom); in_lanes = LANES'($urandom);
  endtask

  task automatic send_words(input int cnt, input logic [W-1:0] ckpat, input bit gaps);
    for (int k = 0; k < cnt; k++)
      for (int b = W-1; b >= 0; b--) begin
        push_sample(ckpat[b], LANES'($urandom));
        if (gaps && ($urandom % 3 == 0)) idle();
      end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (pend) begin
        check(offset == 3'(m_off), "R8 offset", 64'(offset), 64'(m_off));
        check(locked == m_locked, "R9 locked", 64'(locked), 64'(m_locked));
        pend = 0;
      end
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 R5 R6 R7 unexpected strobe", 64'(out_word), 64'(0));
        end else begin
          logic [OW-1:0] e;
          e = exp_q.pop_front();
          check(out_word == e, "R3 R4 word", 64'(out_word), 64'(e));
        end
        if (data_ok) begin
          m_locked = 1'b1; m_miss = 0;
        end else begin
          m_locked = 1'b0; m_miss++;
          if (m_miss == MISS) begin
            m_miss = 0; m_off = (m_off + 1) % 7;
          end
        end
        pend = 1;
        last_word = out_word;
      end else begin
        check(out_word == last_word, "R10 hold", 64'(out_word), 64'(last_word));
      end
    end
  end

  // watchdog
  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog expired", 64'(0), 64'(1));
    wrap_up();
  end

  initial begin
    for (int i = 0; i < 8192; i++) hist[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'(0));
    check(locked == 1'b0, "R1 locked", 64'(locked), 64'(0));
    check(offset == 3'd0, "R1 offset", 64'(offset), 64'(0));
    check(out_word == '0, "R1 out_word", 64'(out_word), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && locked == 1'b0, "R1 after release",
          64'({out_valid, locked}), 64'(0));
    mon_on = 1;

    // R2 R3: conforming clock, target offset 0, dense then gapped
    dok_en = 1'b1; target_off = 0;
    send_words(12, 7'b1111000, 1'b0);
    send_words(12, 7'b1111000, 1'b1);
    // R4 R8: search up to offset 3
    target_off = 3;
    send_words(40, 7'b1111000, 1'b1);
    // R8: search wraps 6 to 0 and lands on 1
    target_off = 1;
    send_words(50, 7'b1111000, 1'b1);
    // R2: 5:2 clock never matches in pattern mode
    send_words(6, 7'b1111100, 1'b1);
    send_words(2, 7'b1111000, 1'b0);

    // R5: edge mode, conforming then 5:2 clock
    idle(); edge_mode = 1'b1;
    send_words(10, 7'b1111000, 1'b1);
    send_words(10, 7'b1111100, 1'b1);
    // R6: spurious high in the low phase must not yield a second word
    send_words(10, 7'b1111010, 1'b1);
    send_words(4, 7'b1111000, 1'b0);

    // R2: back to pattern mode with the glitching clock: no strobes
    idle(); edge_mode = 1'b0;
    send_words(6, 7'b1111010, 1'b1);
    send_words(3, 7'b1111000, 1'b0);

    idle();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R2 R5 missing strobes", 64'(exp_q.size()), 64'(0));
    check(locked == 1'b1, "R9 final lock", 64'(locked), 64'(1));
    check(offset == 3'd1, "R8 final offset", 64'(offset), 64'(1));
    wrap_up();
  end
endmodule